// File: doc/BRIEF.md
# Atomic Bus Release Sequencer

This host-side block closes an addressed transaction on a three-line open-drain serial bus: attention, clock and data, each with a drive-low enable. A single request strobe starts the sequence. The block first writes back the host's fast-mode status byte with its fast-mode bit cleared. It then has an external byte-send engine transmit the unaddress command while attention and clock are pulled low. After that it returns the bus to idle in a fixed order: attention, then clock after a fixed delay, then data.

Another agent could preempt the host between releasing attention and releasing clock, and so stretch that gap without bound. A peripheral that samples the clock line early would then misread the bus. To prevent this, the block raises a preemption mask for the whole of that window. The gap is a down-counter set by a parameter (`DELAY_CYC`, the number of clock cycles in about 60 microseconds), so its length is exact in cycles. A one-cycle done pulse closes the sequence.

Top module: `bus_release_seq`

## Requirements
- R1: One cycle after a request is accepted, `mode_we_o` pulses for exactly one cycle with `mode_wd_o` equal to `mode_rd_i` with bit 7 cleared. This happens before `tx_req_o` is first raised.
- R2: `tx_req_o` is held high, with `tx_byte_o` = 8'h3F and `atn_lo_o`, `clk_lo_o`, `dat_lo_o` all high, until `tx_done_i` is seen high at a clock edge.
- R3: In the cycle after `tx_done_i` is accepted, `atn_lo_o` falls while `clk_lo_o` and `dat_lo_o` stay high. Attention is always the first line released.
- R4: `clk_lo_o` falls exactly `DELAY_CYC` cycles after `atn_lo_o` falls.
- R5: `dat_lo_o` falls exactly one cycle after `clk_lo_o` falls.
- R6: `irq_mask_o` is high from the cycle in which attention is released up to and including the cycle in which clock is released. It is low in every other cycle, including the byte send.
- R7: A request that arrives while a sequence is in progress is ignored. It produces no second status write and no new send once the current sequence ends.
- R8: `done_o` pulses high for exactly one cycle, in the cycle after data is released, with all three drive enables low.
- R9: While `rst_ni` is low, all outputs are low, including in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start strobe |
| mode_rd_i | input | 8 | Current fast-mode status byte |
| mode_we_o | output | 1 | Status byte write strobe |
| mode_wd_o | output | 8 | Status byte write value, fast-mode bit cleared |
| tx_req_o | output | 1 | Byte-send request to the send engine |
| tx_byte_o | output | 8 | Byte to send (8'h3F while requesting) |
| tx_done_i | input | 1 | Byte-send complete |
| atn_lo_o | output | 1 | Drive attention line low |
| clk_lo_o | output | 1 | Drive clock line low |
| dat_lo_o | output | 1 | Drive data line low |
| irq_mask_o | output | 1 | Mask for preempting logic |
| done_o | output | 1 | Sequence complete, one cycle |

## Verification
A wrong state in the sequencer shows up at the drive enables within one cycle of the step where it goes wrong. Examples are a line released out of order, data dropped together with clock, and the mask missing for a cycle of the attention-to-clock window. A delay counter that is loaded or compared wrongly shows only as a release gap longer or shorter than `DELAY_CYC`. The bench therefore measures that gap in cycles for every run, with several send latencies. A busy check that fails to hold off a second request shows up after done, as an extra status write.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CLR  = 3'd1,
    ST_SEND = 3'd2,
    ST_DLY  = 3'd3,
    ST_CLKR = 3'd4,
    ST_DATR = 3'd5,
    ST_DONE = 3'd6
  } brs_state_e;

  typedef struct packed {
    logic atn;
    logic clk;
    logic dat;
    logic mask;
  } brs_lines_t;
endpackage

// File: rtl/brs_delay.sv
module brs_delay #(
  parameter int unsigned CW   = 4,
  parameter int unsigned LOAD = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= CW'(LOAD);
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/brs_mode_clr.sv
module brs_mode_clr #(
  parameter int unsigned MW   = 8,
  parameter int unsigned FBIT = 7
) (
  input  logic          en_i,
  input  logic [MW-1:0] rd_i,
  output logic          we_o,
  output logic [MW-1:0] wd_o
);
  localparam logic [MW-1:0] KEEP = ~(MW'(1) << FBIT);

  assign we_o = en_i;
  assign wd_o = en_i ? (rd_i & KEEP) : '0;
endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       tx_done_i,
  input  logic       dly_zero_i,
  output logic       clr_en_o,
  output logic       tx_req_o,
  output logic       dly_load_o,
  output logic       dly_dec_o,
  output brs_lines_t lines_o,
  output logic       done_o
);
  brs_state_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = ST_CLR;   // req outside idle is dropped
      ST_CLR:  st_d = ST_SEND;
      ST_SEND: if (tx_done_i) st_d = ST_DLY;
      ST_DLY:  if (dly_zero_i) st_d = ST_CLKR;
      ST_CLKR: st_d = ST_DATR;
      ST_DATR: st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign dly_load_o = (st_q == ST_SEND) && tx_done_i;
  assign dly_dec_o  = (st_q == ST_DLY);
  assign clr_en_o   = (st_q == ST_CLR);
  assign tx_req_o   = (st_q == ST_SEND);
  assign done_o     = (st_q == ST_DONE);

  always_comb begin
    lines_o = '0;
    unique case (st_q)
      ST_CLR, ST_SEND: lines_o = '{atn: 1'b1, clk: 1'b1, dat: 1'b1, mask: 1'b0};
      ST_DLY:          lines_o = '{atn: 1'b0, clk: 1'b1, dat: 1'b1, mask: 1'b1};
      ST_CLKR:         lines_o = '{atn: 1'b0, clk: 1'b0, dat: 1'b1, mask: 1'b1};
      default:         lines_o = '0;
    endcase
  end
endmodule

// File: rtl/bus_release_seq.sv
module bus_release_seq
  import brs_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 7500,
  parameter int unsigned MW        = 8,
  parameter int unsigned FBIT      = 7,
  parameter logic [7:0]  CMD_BYTE  = 8'h3F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [MW-1:0] mode_rd_i,
  output logic          mode_we_o,
  output logic [MW-1:0] mode_wd_o,
  output logic          tx_req_o,
  output logic [7:0]    tx_byte_o,
  input  logic          tx_done_i,
  output logic          atn_lo_o,
  output logic          clk_lo_o,
  output logic          dat_lo_o,
  output logic          irq_mask_o,
  output logic          done_o
);
  localparam int unsigned CW = $clog2(DELAY_CYC + 1) + 1;

  logic       clr_en, dly_load, dly_dec, dly_zero;
  brs_lines_t lines;

  brs_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .tx_done_i  (tx_done_i),
    .dly_zero_i (dly_zero),
    .clr_en_o   (clr_en),
    .tx_req_o   (tx_req_o),
    .dly_load_o (dly_load),
    .dly_dec_o  (dly_dec),
    .lines_o    (lines),
    .done_o     (done_o)
  );

  brs_delay #(.CW(CW), .LOAD(DELAY_CYC - 1)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dly_load),
    .dec_i  (dly_dec),
    .zero_o (dly_zero)
  );

  brs_mode_clr #(.MW(MW), .FBIT(FBIT)) u_clr (
    .en_i (clr_en),
    .rd_i (mode_rd_i),
    .we_o (mode_we_o),
    .wd_o (mode_wd_o)
  );

  assign tx_byte_o  = tx_req_o ? CMD_BYTE : 8'h00;
  assign atn_lo_o   = lines.atn;
  assign clk_lo_o   = lines.clk;
  assign dat_lo_o   = lines.dat;
  assign irq_mask_o = lines.mask;
endmodule

// File: rtl/brs_chk.sv
module brs_chk #(
  parameter int unsigned DELAY_CYC = 7500
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_we_o,
  input logic       tx_req_o,
  input logic [7:0] tx_byte_o,
  input logic       tx_done_i,
  input logic       atn_lo_o,
  input logic       clk_lo_o,
  input logic       dat_lo_o,
  input logic       irq_mask_o,
  input logic       done_o
);
  logic [31:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    gap_q <= '0;
    else if (!atn_lo_o && clk_lo_o) gap_q <= gap_q + 1'b1;
    else                            gap_q <= '0;
  end

  a_r1_clear_before_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_req_o) |-> $past(mode_we_o));

  a_r1_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_o |=> !mode_we_o);

  a_r2_send_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> (atn_lo_o && clk_lo_o && dat_lo_o && tx_byte_o == 8'h3F));

  a_r2_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && !tx_done_i) |=> tx_req_o);

  a_r3_atn_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(atn_lo_o) |-> (clk_lo_o && dat_lo_o));

  a_r4_gap_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_lo_o) |-> (gap_q == DELAY_CYC));

  a_r5_dat_after_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dat_lo_o) |-> ($past(!clk_lo_o) && !atn_lo_o));

  a_r6_mask_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!atn_lo_o && clk_lo_o) |-> irq_mask_o);

  a_r6_mask_off_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> !irq_mask_o);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!atn_lo_o && !clk_lo_o && !dat_lo_o && !irq_mask_o) ##1 !done_o);
endmodule

bind bus_release_seq brs_chk #(.DELAY_CYC(DELAY_CYC)) u_brs_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_we_o  (mode_we_o),
  .tx_req_o   (tx_req_o),
  .tx_byte_o  (tx_byte_o),
  .tx_done_i  (tx_done_i),
  .atn_lo_o   (atn_lo_o),
  .clk_lo_o   (clk_lo_o),
  .dat_lo_o   (dat_lo_o),
  .irq_mask_o (irq_mask_o),
  .done_o     (done_o)
);

// File: tb/sim_bus_release_seq.sv
module sim_bus_release_seq;
  localparam int unsigned DLY = 9;
  localparam int NV = 5;
  // {mode_rd, send latency}
  localparam logic [11:0] VEC [NV] = '{
    {8'hFF, 4'd0}, {8'h80, 4'd3}, {8'h00, 4'd1}, {8'h7F, 4'd5}, {8'hA5, 4'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [7:0] mode_rd = '0;
  logic       tx_done = 1'b0;
  logic       mode_we, tx_req, atn_lo, clk_lo, dat_lo, irq_mask, done;
  logic [7:0] mode_wd, tx_byte;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_release_seq #(.DELAY_CYC(DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_rd_i(mode_rd),
    .mode_we_o(mode_we), .mode_wd_o(mode_wd), .tx_req_o(tx_req),
    .tx_byte_o(tx_byte), .tx_done_i(tx_done), .atn_lo_o(atn_lo),
    .clk_lo_o(clk_lo), .dat_lo_o(dat_lo), .irq_mask_o(irq_mask), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    summary();
  end

  task automatic run_seq(input logic [7:0] rd, input int lat, input bit poke);
    int t_we = -1, t_tx = -1, t_atn = -1, t_clk = -1, t_dat = -1, t_done = -1;
    int n_we = 0, n_tx = 0, n_done = 0, extra_we = 0, extra_atn = 0;
    bit send_bad = 0, wd_bad = 0, mask_send = 0;
    bit m_atn = 0, m_clk = 0, m_dat = 1, poked = 0;
    logic [7:0] wd_seen = '0;
    @(negedge clk);
    mode_rd = rd;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int t = 0; t < 200 && t_done < 0; t++) begin
      if (poked) req = 1'b0;
      if (mode_we) begin
        n_we++;
        if (t_we < 0) t_we = t;
        wd_seen = mode_wd;
        if (mode_wd != (rd & 8'h7F)) wd_bad = 1;
      end
      if (tx_req) begin
        if (t_tx < 0) t_tx = t;
        n_tx++;
        if (!(atn_lo && clk_lo && dat_lo && tx_byte == 8'h3F)) send_bad = 1;
        if (irq_mask) mask_send = 1;
      end
      tx_done = tx_req && (n_tx == lat + 1);
      if (t_tx >= 0 && !atn_lo && t_atn < 0) begin
        t_atn = t; m_atn = irq_mask;
        if (!(clk_lo && dat_lo)) send_bad = 1;
        if (poke) begin req = 1'b1; poked = 1; end
      end
      if (t_atn >= 0 && !clk_lo && t_clk < 0) begin t_clk = t; m_clk = irq_mask; end
      if (t_clk >= 0 && !dat_lo && t_dat < 0) begin t_dat = t; m_dat = irq_mask; end
      if (done) begin
        t_done = t; n_done++;
        if (atn_lo || clk_lo || dat_lo) send_bad = 1;
      end
      @(negedge clk);
    end
    req = 1'b0;
    tx_done = 1'b0;
    for (int t = 0; t < 15; t++) begin
      if (done) n_done++;
      if (mode_we) extra_we++;
      if (atn_lo) extra_atn++;
      @(negedge clk);
    end
    chk(n_we == 1 && !wd_bad && t_we == 0, "R1 status write", int'(wd_seen), int'(rd & 8'h7F));
    chk(t_we >= 0 && t_tx > t_we, "R1 write before send", t_tx, t_we + 1);
    chk(!send_bad && n_tx == lat + 1, "R2 send phase", n_tx, lat + 1);
    chk(t_atn == t_tx + lat + 1, "R3 atn release cycle", t_atn, t_tx + lat + 1);
    chk(t_clk - t_atn == DLY, "R4 atn-to-clk gap", t_clk - t_atn, DLY);
    chk(t_dat - t_clk == 1, "R5 clk-to-dat gap", t_dat - t_clk, 1);
    chk(m_atn && m_clk && !m_dat && !mask_send, "R6 mask window",
        int'({mask_send, m_atn, m_clk, m_dat}), 4'b0110);
    chk(t_done - t_dat == 1 && n_done == 1, "R8 done pulse", n_done, 1);
    if (poke) chk(extra_we == 0 && extra_atn == 0, "R7 busy request ignored", extra_we, 0);
  endtask

  initial begin
    #20;
    @(negedge clk);
    chk({mode_we, tx_req, atn_lo, clk_lo, dat_lo, irq_mask, done} == '0,
        "R9 outputs in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mode_we, tx_req, atn_lo, clk_lo, dat_lo, irq_mask, done} == '0,
        "R9 idle after reset", 1, 0);

    for (int i = 0; i < NV; i++) run_seq(VEC[i][11:4], int'(VEC[i][3:0]), 1'b0);

    // request during the release gap
    run_seq(8'hC3, 2, 1'b1);

    // reset in the middle of the gap
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int t = 0; t < 50 && atn_lo; t++) begin
      tx_done = tx_req;
      @(negedge clk);
    end
    tx_done = 1'b0;
    @(negedge clk);
    chk(clk_lo && irq_mask, "R6 mid-gap state", int'(irq_mask), 1);
    #1 rst_n = 1'b0;
    #1;
    chk({mode_we, tx_req, atn_lo, clk_lo, dat_lo, irq_mask, done} == '0,
        "R9 async reset mid-sequence", int'({clk_lo, irq_mask}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_seq(8'h81, 0, 1'b0);
    summary();
  end
endmodule